// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Manager

This block keeps the two indices of a receive descriptor ring. The host posts buffers by writing a producer index. The block hands descriptors to the receive path one at a time and advances its own consumer index as it does so. When a frame ends bad, the consumer returns to the descriptor where that frame began, so the frame's buffers are used again. The block also counts frames dropped while the data FIFO was full and the ring had nothing to offer. A status bit tells the host whether a receive data burst could start at present.

Software reaches the block through a small word-wide register port with three registers. The pointer register (select 0) holds the producer in bits 10:0 and the consumer in bits 26:16. The status register (select 1) holds the lost-frame count in bits 15:0 and the no-burst flag in bit 16. The control register (select 2) holds the consumer write-enable in bit 0 and the DMA enable in bit 1. The receive path talks to the block through single-cycle pulses: frame open, descriptor request with a same-cycle grant, frame close with a bad flag, and frame drop with a FIFO-full level.

Top module: `rxr_ptr_mgr`

## Requirements
- R1: After reset the pointer, status count and control fields read zero, the no-burst flag (status bit 16) reads 1, and no grant is given.
- R2: A write to the pointer register (select 0) loads the producer from bits 10:0. Reserved bits of every register read zero, and select 3 reads zero.
- R3: A descriptor request is granted in the same cycle when a frame is open, it is not the frame's closing cycle, DMA is enabled and the ring is not empty. The consumer then moves on by one in the next cycle and wraps from RING_SIZE-1 to 0. `desc_idx` gives the index of the descriptor granted.
- R4: The ring is empty when consumer equals producer. A request in that state gets no grant and leaves the consumer unchanged.
- R5: A frame that closes with the bad flag set returns the consumer to its value at the frame's first request. A frame that closes good, or that made no request, leaves the consumer where it is.
- R6: A host write to the consumer field (bits 26:16) takes effect only while control bit 0 is 1. Otherwise the field keeps its value.
- R7: The lost-frame count (status bits 15:0) rises by one on a drop pulse while the FIFO is full and the ring is empty. It does not change on any other drop pulse. It stops at 0xFFFF, and a host write to the status register loads it.
- R8: The no-burst flag is 0 only while DMA is enabled (control bit 1), a frame is open and a descriptor has been granted in that frame. With DMA disabled no grant is given.
- R9: Control bits 0 and 1 are writable and read back. The other control bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pointer, 1 status, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| frm_start | input | 1 | Pulse: a new frame opens |
| desc_req | input | 1 | Pulse: the receive path asks for the next descriptor |
| desc_gnt | output | 1 | The request in this cycle is granted |
| desc_idx | output | IDX_W | Index of the descriptor handed out (the current consumer) |
| frm_end | input | 1 | Pulse: the open frame closes |
| frm_bad | input | 1 | With frm_end: the frame was bad |
| fifo_full | input | 1 | Receive data FIFO is full |
| frm_drop | input | 1 | Pulse: the receive path dropped a frame |

## Verification
A wrong consumer shows in the pointer register read on the cycle after the grant or the frame close that moved it. It also shows in the grant of the next request, because emptiness is decided from the consumer. A start index latched from the wrong request shows only when a bad frame closes, so the bench closes bad frames after several grants, starting from every consumer position and across the wrap. A counter fault shows at the status read right after each drop pulse, with the saturation point reached by preloading the count.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned PROD_LSB   = 0;
   localparam int unsigned CONS_LSB   = 16;
   localparam int unsigned NOBURST_BIT = 16;
   localparam int unsigned CWE_BIT    = 0;
   localparam int unsigned DMAEN_BIT  = 1;

   typedef enum logic [1:0] {
      SEL_PTR  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic dma_en;
      logic cons_we;
   } ctrl_t;
endpackage

// File: rtl/rxr_idx_step.sv
module rxr_idx_step #(
   parameter int unsigned RING = 2048,
   parameter int unsigned W    = 11
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   localparam bit IS_POW2 = ((RING & (RING - 1)) == 0);
   localparam logic [W-1:0] LAST = W'(RING - 1);

   generate
      if (IS_POW2) begin : g_mask
         always_comb nxt = (cur + W'(1)) & LAST;
      end else begin : g_cmp
         always_comb nxt = (cur == LAST) ? '0 : cur + W'(1);
      end
   endgenerate
endmodule

// File: rtl/rxr_ring_ptrs.sv
module rxr_ring_ptrs #(
   parameter int unsigned RING = 2048,
   parameter int unsigned W    = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         host_prod_we,
   input  logic [W-1:0] host_prod,
   input  logic         host_cons_we,
   input  logic [W-1:0] host_cons,
   input  logic         frm_open,
   input  logic         req_seen,
   input  logic         adv,
   input  logic         end_any,
   input  logic         end_bad,
   output logic [W-1:0] cons,
   output logic [W-1:0] prod,
   output logic         empty
);
   logic [W-1:0] cons_nxt;
   logic [W-1:0] start_q;
   logic         latched_q;

   rxr_idx_step #(.RING(RING), .W(W)) i_step (.cur(cons), .nxt(cons_nxt));

   assign empty = (cons == prod);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else if (host_prod_we) prod <= host_prod;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cons <= '0;
      else if (host_cons_we) cons <= host_cons;
      else if (end_bad && latched_q) cons <= start_q;
      else if (adv) cons <= cons_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= '0;
         latched_q <= 1'b0;
      end else if (frm_open || end_any) begin
         latched_q <= 1'b0;
      end else if (req_seen && !latched_q) begin
         start_q   <= cons;
         latched_q <= 1'b1;
      end
   end

   a_r3_step_moves : assert property (@(posedge clk) disable iff (!rst_n)
      adv && !host_cons_we && !end_bad |=> cons != $past(cons));
   a_r4_no_adv_empty : assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !adv);
   a_r5_rollback : assert property (@(posedge clk) disable iff (!rst_n)
      end_bad && latched_q && !host_cons_we |=> cons == $past(start_q));
   a_r6_hold_cons : assert property (@(posedge clk) disable iff (!rst_n)
      !host_cons_we && !end_bad && !adv |=> $stable(cons));
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic frm_start,
   input  logic desc_req,
   input  logic frm_end,
   input  logic frm_bad,
   input  logic dma_en,
   input  logic empty,
   output logic gnt,
   output logic req_seen,
   output logic end_any,
   output logic end_bad,
   output logic nonburst
);
   logic active_q;
   logic held_q;

   assign end_any  = frm_end && active_q;
   assign end_bad  = end_any && frm_bad;
   assign req_seen = desc_req && active_q && !frm_end;
   assign gnt      = req_seen && dma_en && !empty;
   assign nonburst = !(dma_en && active_q && held_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         held_q   <= 1'b0;
      end else begin
         if (frm_start) active_q <= 1'b1;
         else if (end_any) active_q <= 1'b0;
         if (frm_start || end_any) held_q <= 1'b0;
         else if (gnt) held_q <= 1'b1;
      end
   end

   a_r8_no_gnt_off : assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !gnt);
   a_r8_nb_off : assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> nonburst);
   a_r3_no_gnt_closing : assert property (@(posedge clk) disable iff (!rst_n)
      frm_end |-> !gnt);
endmodule

// File: rtl/rxr_lost_ctr.sv
module rxr_lost_ctr #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (wr_en) cnt <= wr_val;
      else if (inc && cnt != MAXV) cnt <= cnt + W'(1);
   end

   a_r7_saturate : assert property (@(posedge clk) disable iff (!rst_n)
      cnt == MAXV && !wr_en |=> cnt == MAXV);
   a_r7_step : assert property (@(posedge clk) disable iff (!rst_n)
      inc && !wr_en && cnt != MAXV |=> cnt == $past(cnt) + W'(1));
   a_r7_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !inc && !wr_en |=> $stable(cnt));
endmodule

// File: rtl/rxr_ptr_mgr.sv
module rxr_ptr_mgr
   import rxr_pkg::*;
#(
   parameter int unsigned RING_SIZE = 2048,
   parameter int unsigned IDX_W     = 11,
   parameter int unsigned CNT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              frm_start,
   input  logic              desc_req,
   output logic              desc_gnt,
   output logic [IDX_W-1:0]  desc_idx,
   input  logic              frm_end,
   input  logic              frm_bad,
   input  logic              fifo_full,
   input  logic              frm_drop
);
   generate
      if (IDX_W < 1 || IDX_W > CONS_LSB - 1) begin : g_bad_idx
         $error("IDX_W out of range");
      end
      if (RING_SIZE < 2 || RING_SIZE > (1 << IDX_W)) begin : g_bad_ring
         $error("RING_SIZE must lie in 2 .. 2**IDX_W");
      end
      if (CNT_W < 1 || CNT_W > NOBURST_BIT) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
   endgenerate

   reg_sel_e         sel;
   ctrl_t            ctrl_q;
   logic             prod_we, cons_we, stat_we, ctrl_we;
   logic [IDX_W-1:0] cons, prod;
   logic [CNT_W-1:0] lost;
   logic             empty, req_seen, end_any, end_bad, nonburst;

   assign sel     = reg_sel_e'(reg_addr);
   assign prod_we = reg_wr && (sel == SEL_PTR);
   assign cons_we = prod_we && ctrl_q.cons_we;
   assign stat_we = reg_wr && (sel == SEL_STAT);
   assign ctrl_we = reg_wr && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_we) begin
         ctrl_q.cons_we <= reg_wdata[CWE_BIT];
         ctrl_q.dma_en  <= reg_wdata[DMAEN_BIT];
      end
   end

   rxr_frame_ctl i_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_start(frm_start),
      .desc_req (desc_req),
      .frm_end  (frm_end),
      .frm_bad  (frm_bad),
      .dma_en   (ctrl_q.dma_en),
      .empty    (empty),
      .gnt      (desc_gnt),
      .req_seen (req_seen),
      .end_any  (end_any),
      .end_bad  (end_bad),
      .nonburst (nonburst)
   );

   rxr_ring_ptrs #(.RING(RING_SIZE), .W(IDX_W)) i_ptrs (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_prod_we(prod_we),
      .host_prod   (reg_wdata[PROD_LSB +: IDX_W]),
      .host_cons_we(cons_we),
      .host_cons   (reg_wdata[CONS_LSB +: IDX_W]),
      .frm_open    (frm_start),
      .req_seen    (req_seen),
      .adv         (desc_gnt),
      .end_any     (end_any),
      .end_bad     (end_bad),
      .cons        (cons),
      .prod        (prod),
      .empty       (empty)
   );

   rxr_lost_ctr #(.W(CNT_W)) i_lost (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (stat_we),
      .wr_val(reg_wdata[CNT_W-1:0]),
      .inc   (frm_drop && fifo_full && empty),
      .cnt   (lost)
   );

   assign desc_idx = cons;

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_PTR: begin
            reg_rdata[PROD_LSB +: IDX_W] = prod;
            reg_rdata[CONS_LSB +: IDX_W] = cons;
         end
         SEL_STAT: begin
            reg_rdata[CNT_W-1:0]  = lost;
            reg_rdata[NOBURST_BIT] = nonburst;
         end
         SEL_CTRL: begin
            reg_rdata[CWE_BIT]   = ctrl_q.cons_we;
            reg_rdata[DMAEN_BIT] = ctrl_q.dma_en;
         end
         default: reg_rdata = '0;
      endcase
   end

   a_r2_reserved_zero : assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_PTR |-> reg_rdata[CONS_LSB-1:IDX_W] == '0);
   a_r3_gnt_nonempty : assert property (@(posedge clk) disable iff (!rst_n)
      desc_gnt |-> prod != cons);
endmodule

// File: tb/test_rxr_ptr_mgr.sv
module test_rxr_ptr_mgr;
   localparam int RING = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        frm_start = 1'b0, desc_req = 1'b0, frm_end = 1'b0, frm_bad = 1'b0;
   logic        fifo_full = 1'b0, frm_drop = 1'b0;
   logic        desc_gnt;
   logic [10:0] desc_idx;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rxr_ptr_mgr #(.RING_SIZE(RING), .IDX_W(11), .CNT_W(16)) i_rxr_ptr_mgr (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_start(frm_start),
      .desc_req(desc_req), .desc_gnt(desc_gnt), .desc_idx(desc_idx),
      .frm_end(frm_end), .frm_bad(frm_bad), .fifo_full(fifo_full),
      .frm_drop(frm_drop)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic open_frame();
      @(negedge clk); frm_start = 1'b1;
      @(negedge clk); frm_start = 1'b0;
   endtask

   task automatic close_frame(input logic is_bad);
      @(negedge clk); frm_end = 1'b1; frm_bad = is_bad;
      @(negedge clk); frm_end = 1'b0; frm_bad = 1'b0;
   endtask

   task automatic request(output logic g, output logic [10:0] idx);
      @(negedge clk); desc_req = 1'b1;
      #1 g = desc_gnt; idx = desc_idx;
      @(negedge clk); desc_req = 1'b0;
   endtask

   task automatic drop(input logic full);
      @(negedge clk); frm_drop = 1'b1; fifo_full = full;
      @(negedge clk); frm_drop = 1'b0; fifo_full = 1'b0;
   endtask

   function automatic logic [31:0] ptrv(input int c, input int p);
      return (32'(c) << 16) | 32'(p);
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic g;
      logic [10:0] idx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, d); check("R1 ptr", d, 0);
      rd(2'd1, d); check("R1 stat", d, 32'h0001_0000);
      rd(2'd2, d); check("R1 ctrl", d, 0);
      check("R1 gnt", {31'd0, desc_gnt}, 0);

      // R2 + R6: write all ones with consumer write disabled
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R2 R6 ptr layout", d, 32'h0000_07FF);
      rd(2'd3, d); check("R2 sel3", d, 0);

      // R9 control
      wr(2'd2, 32'h3); rd(2'd2, d); check("R9 ctrl set", d, 3);
      wr(2'd2, 32'hFFFF_FFFC); rd(2'd2, d); check("R9 ctrl clear", d, 0);
      wr(2'd2, 32'h3);

      // R3/R4 sweep over every consumer/producer pair
      for (int c = 0; c < RING; c++) begin
         for (int p = 0; p < RING; p++) begin
            wr(2'd0, ptrv(c, p));
            open_frame();
            request(g, idx);
            check($sformatf("R3 R4 gnt c=%0d p=%0d", c, p), {31'd0, g}, {31'd0, c != p});
            check("R3 desc_idx", {21'd0, idx}, 32'(c));
            rd(2'd0, d);
            check($sformatf("R3 R4 cons c=%0d p=%0d", c, p), d,
                  ptrv((c != p) ? (c + 1) % RING : c, p));
            close_frame(1'b0);
            rd(2'd0, d);
            check("R5 good keeps", d, ptrv((c != p) ? (c + 1) % RING : c, p));
         end
      end

      // R5 rollback and R8 burst flag
      for (int c = 0; c < RING; c++) begin
         int p;
         p = (c + 5) % RING;
         wr(2'd0, ptrv(c, p));
         open_frame();
         rd(2'd1, d); check("R8 nb before grant", {31'd0, d[16]}, 1);
         request(g, idx);
         request(g, idx);
         rd(2'd1, d); check("R8 nb held", {31'd0, d[16]}, 0);
         close_frame(1'b1);
         rd(2'd0, d); check($sformatf("R5 rollback c=%0d", c), d, ptrv(c, p));
         open_frame();
         request(g, idx);
         request(g, idx);
         close_frame(1'b0);
         rd(2'd0, d); check($sformatf("R5 good c=%0d", c), d, ptrv((c + 2) % RING, p));
      end
      wr(2'd0, ptrv(4, 1));
      open_frame(); close_frame(1'b1);
      rd(2'd0, d); check("R5 bad no request", d, ptrv(4, 1));

      // R6 consumer write ignored without enable
      wr(2'd2, 32'h2);
      wr(2'd0, ptrv(3, 2));
      rd(2'd0, d); check("R6 ignored", d, ptrv(4, 2));

      // R8 DMA disabled
      wr(2'd2, 32'h1);
      wr(2'd0, ptrv(0, 3));
      open_frame();
      request(g, idx);
      check("R8 no gnt dma off", {31'd0, g}, 0);
      rd(2'd1, d); check("R8 nb dma off", {31'd0, d[16]}, 1);
      rd(2'd0, d); check("R8 cons held", d, ptrv(0, 3));
      close_frame(1'b0);

      // R7 lost counter
      wr(2'd2, 32'h3);
      wr(2'd0, ptrv(2, 2));
      drop(1'b1); rd(2'd1, d); check("R7 inc", {16'd0, d[15:0]}, 1);
      drop(1'b0); rd(2'd1, d); check("R7 not full", {16'd0, d[15:0]}, 1);
      wr(2'd0, ptrv(2, 4));
      drop(1'b1); rd(2'd1, d); check("R7 not empty", {16'd0, d[15:0]}, 1);
      wr(2'd0, ptrv(4, 4));
      wr(2'd1, 32'h0000_FFFE);
      rd(2'd1, d); check("R7 load", {16'd0, d[15:0]}, 32'hFFFE);
      drop(1'b1); rd(2'd1, d); check("R7 reach max", {16'd0, d[15:0]}, 32'hFFFF);
      drop(1'b1); rd(2'd1, d); check("R7 saturate", {16'd0, d[15:0]}, 32'hFFFF);
      wr(2'd1, 32'h5); rd(2'd1, d); check("R7 reload", {16'd0, d[15:0]}, 5);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule